// File: doc/BRIEF.md
# Character and Cursor Memory Store

This block is the storage core of a small alphanumeric display controller with four character positions. It keeps one 7-bit character code per position and, apart from that, a one-bit cursor flag per position. Both stores share a 2-bit position index, and index 0 is the rightmost position on the display. A host loads them through a simple parallel write port. The write is qualified by two active-low enables and an active-low strobe, and a select line chooses which store receives the write.

A scan counter steps through the positions at a fixed rate set by a parameter. It drives the position output for the downstream multiplexer, and it also sets the order in which a timed clear erases the character store. The clear zeroes the position under scan on every cycle it is active, so all positions are empty only after one complete scan with clear held. Clear never touches the cursor flags, and clear is inhibited while blanking is asserted. Blanking also holds the scan counter at position 0. A combinational read port returns the code, a validity flag and the cursor flag for any position. Segment decoding, digit multiplexing and drive are left to other blocks.

Top module: `char_cursor_store`

## Requirements
- R1: After reset all character codes are 0, all cursor flags are 0 and `scan_pos` is 0.
- R2: When `ce1_n`, `ce2_n` and `wr_n` are all 0 and `cur_sel` is 1 at a clock edge, `wr_data[6:0]` is stored at position `wr_addr`. It appears on the read port from the next cycle.
- R3: When any of `ce1_n`, `ce2_n` or `wr_n` is 1, a clock edge changes neither store, unless a clear is active.
- R4: A write with `cur_sel` 0 sets the cursor flag at `wr_addr` when `wr_data[0]` is 1 and removes it when `wr_data[0]` is 0. The character at that position keeps its value.
- R5: `rd_code_valid` is 1 exactly when bit 6 of the code read differs from bit 5. A code whose bit 6 equals its bit 5 counts as blank.
- R6: When `clr_n` is 0 and `blank_n` is 1 at an edge, the character at the current `scan_pos` becomes 0, whatever the chip enables are. After NUM_POS*STEP_CYC such cycles all codes are 0.
- R7: Clear leaves all cursor flags unchanged, and cursor writes take effect while clear is active.
- R8: While `blank_n` is 0, clear has no effect, and both character and cursor writes are still accepted.
- R9: With `blank_n` at 1, `scan_pos` advances by one, modulo 4, every STEP_CYC cycles. A cycle with `blank_n` at 0 returns it to 0 and restarts its step count.
- R10: When a clear and a character write hit the same position in the same cycle, the clear wins and the position holds 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce1_n | input | 1 | Chip enable 1, active low |
| ce2_n | input | 1 | Chip enable 2, active low |
| wr_n | input | 1 | Write strobe, active low |
| cur_sel | input | 1 | 1 selects the character store, 0 selects the cursor store |
| wr_addr | input | 2 | Position written, 0 is the rightmost |
| wr_data | input | 7 | Character code; bit 0 alone is used for cursor writes |
| clr_n | input | 1 | Clear request, active low |
| blank_n | input | 1 | Blanking, active low |
| rd_addr | input | 2 | Position read |
| rd_code | output | 7 | Stored code at `rd_addr` |
| rd_code_valid | output | 1 | Code at `rd_addr` is displayable (bit 6 differs from bit 5) |
| rd_cursor | output | 1 | Cursor flag at `rd_addr` |
| scan_pos | output | 2 | Position currently under scan |

## Verification
Writes, clears and scan steps are all registered once, so each effect shows at the ports in the cycle after the edge that sampled the stimulus. The read port is combinational on `rd_addr`, so a read reflects the current contents without any extra delay. The bench drives inputs on the falling edge and updates its model right after the rising edge. It then sweeps `rd_addr` on the falling edge and compares all four positions and `scan_pos` with the model on every cycle. A clear therefore has to be seen erasing one position per scan step, not all positions at once.

// File: rtl/chstore_pkg.sv
package chstore_pkg;

   // write operation decoded from the host strobes
   typedef enum logic [1:0] {
      OP_NONE = 2'd0,
      OP_CHAR = 2'd1,
      OP_CURS = 2'd2
   } wr_op_e;

   // a code is displayable only when its two top bits differ
   function automatic logic code_displayable(input logic hi_bit, input logic lo_bit);
      return hi_bit ^ lo_bit;
   endfunction

endpackage

// File: rtl/chstore_scan.sv
module chstore_scan #(
   parameter int NUM_POS  = 4,
   parameter int STEP_CYC = 4,
   localparam int ADDR_W  = $clog2(NUM_POS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   output logic [ADDR_W-1:0] pos_o
);

   logic [ADDR_W-1:0] pos_q;

   generate
      if (STEP_CYC == 1) begin : g_every_cycle
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      pos_q <= '0;
            else if (!run)   pos_q <= '0;
            else             pos_q <= pos_q + ADDR_W'(1);
         end
      end else begin : g_prescaled
         localparam int DIV_W = $clog2(STEP_CYC);
         localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(STEP_CYC - 1);
         logic [DIV_W-1:0] div_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               div_q <= '0;
               pos_q <= '0;
            end else if (!run) begin
               div_q <= '0;
               pos_q <= '0;
            end else if (div_q == DIV_LAST) begin
               div_q <= '0;
               pos_q <= pos_q + ADDR_W'(1);
            end else begin
               div_q <= div_q + DIV_W'(1);
            end
         end
      end
   endgenerate

   assign pos_o = pos_q;

endmodule

// File: rtl/chstore_ctrl.sv
module chstore_ctrl
   import chstore_pkg::*;
(
   input  logic   ce1_n,
   input  logic   ce2_n,
   input  logic   wr_n,
   input  logic   cur_sel,
   input  logic   clr_n,
   input  logic   blank_n,
   output wr_op_e op_o,
   output logic   clr_act_o
);

   logic strobe;

   assign strobe = ~(ce1_n | ce2_n | wr_n);

   always_comb begin
      op_o = OP_NONE;
      if (strobe) begin
         if (cur_sel) op_o = OP_CHAR;
         else         op_o = OP_CURS;
      end
   end

   // blanking inhibits clear; enables play no part in it
   assign clr_act_o = ~clr_n & blank_n;

endmodule

// File: rtl/chstore_char_mem.sv
module chstore_char_mem #(
   parameter int NUM_POS  = 4,
   parameter int CODE_W   = 7,
   localparam int ADDR_W  = $clog2(NUM_POS),
   localparam int FLAT_W  = NUM_POS * CODE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [CODE_W-1:0] wr_data,
   input  logic              clr_en,
   input  logic [ADDR_W-1:0] clr_addr,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [CODE_W-1:0] rd_data,
   output logic [FLAT_W-1:0] flat_o
);

   generate
      for (genvar i = 0; i < NUM_POS; i++) begin : g_ent
         logic [CODE_W-1:0] ent_q;
         logic              hit_clr;
         logic              hit_wr;

         assign hit_clr = clr_en & (clr_addr == ADDR_W'(i));
         assign hit_wr  = wr_en  & (wr_addr  == ADDR_W'(i));

         // clear takes priority over a write to the same entry
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       ent_q <= '0;
            else if (hit_clr) ent_q <= '0;
            else if (hit_wr)  ent_q <= wr_data;
         end

         assign flat_o[i*CODE_W +: CODE_W] = ent_q;
      end
   endgenerate

   always_comb begin
      rd_data = '0;
      for (int k = 0; k < NUM_POS; k++) begin
         if (rd_addr == ADDR_W'(k)) rd_data = flat_o[k*CODE_W +: CODE_W];
      end
   end

endmodule

// File: rtl/chstore_cur_mem.sv
module chstore_cur_mem #(
   parameter int NUM_POS  = 4,
   localparam int ADDR_W  = $clog2(NUM_POS)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [ADDR_W-1:0]  wr_addr,
   input  logic               wr_flag,
   input  logic [ADDR_W-1:0]  rd_addr,
   output logic               rd_flag,
   output logic [NUM_POS-1:0] flags_o
);

   generate
      for (genvar i = 0; i < NUM_POS; i++) begin : g_flag
         logic flag_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                  flag_q <= 1'b0;
            else if (wr_en && wr_addr == ADDR_W'(i))     flag_q <= wr_flag;
         end

         assign flags_o[i] = flag_q;
      end
   endgenerate

   always_comb begin
      rd_flag = 1'b0;
      for (int k = 0; k < NUM_POS; k++) begin
         if (rd_addr == ADDR_W'(k)) rd_flag = flags_o[k];
      end
   end

endmodule

// File: rtl/char_cursor_store.sv
module char_cursor_store
   import chstore_pkg::*;
#(
   parameter int NUM_POS  = 4,
   parameter int CODE_W   = 7,
   parameter int STEP_CYC = 4,
   localparam int ADDR_W  = $clog2(NUM_POS),
   localparam int FLAT_W  = NUM_POS * CODE_W,
   localparam int HI_BIT  = CODE_W - 1,
   localparam int LO_BIT  = CODE_W - 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce1_n,
   input  logic              ce2_n,
   input  logic              wr_n,
   input  logic              cur_sel,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [CODE_W-1:0] wr_data,
   input  logic              clr_n,
   input  logic              blank_n,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [CODE_W-1:0] rd_code,
   output logic              rd_code_valid,
   output logic              rd_cursor,
   output logic [ADDR_W-1:0] scan_pos
);

   generate
      if (NUM_POS < 2 || (1 << ADDR_W) != NUM_POS) begin : g_bad_pos
         $error("NUM_POS must be a power of two of at least 2");
      end
      if (CODE_W < 2) begin : g_bad_code
         $error("CODE_W must be at least 2");
      end
      if (STEP_CYC < 1) begin : g_bad_step
         $error("STEP_CYC must be at least 1");
      end
   endgenerate

   wr_op_e             op;
   logic               clr_act;
   logic [FLAT_W-1:0]  char_flat;
   logic [NUM_POS-1:0] cur_flat;

   chstore_ctrl u_ctrl (
      .ce1_n     (ce1_n),
      .ce2_n     (ce2_n),
      .wr_n      (wr_n),
      .cur_sel   (cur_sel),
      .clr_n     (clr_n),
      .blank_n   (blank_n),
      .op_o      (op),
      .clr_act_o (clr_act)
   );

   chstore_scan #(
      .NUM_POS  (NUM_POS),
      .STEP_CYC (STEP_CYC)
   ) u_scan (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (blank_n),
      .pos_o (scan_pos)
   );

   chstore_char_mem #(
      .NUM_POS (NUM_POS),
      .CODE_W  (CODE_W)
   ) u_char (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (op == OP_CHAR),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .clr_en   (clr_act),
      .clr_addr (scan_pos),
      .rd_addr  (rd_addr),
      .rd_data  (rd_code),
      .flat_o   (char_flat)
   );

   chstore_cur_mem #(
      .NUM_POS (NUM_POS)
   ) u_cur (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (op == OP_CURS),
      .wr_addr (wr_addr),
      .wr_flag (wr_data[0]),
      .rd_addr (rd_addr),
      .rd_flag (rd_cursor),
      .flags_o (cur_flat)
   );

   assign rd_code_valid = code_displayable(rd_code[HI_BIT], rd_code[LO_BIT]);

endmodule

// File: rtl/chstore_chk.sv
module chstore_chk #(
   parameter int NUM_POS  = 4,
   parameter int CODE_W   = 7,
   localparam int ADDR_W  = $clog2(NUM_POS),
   localparam int FLAT_W  = NUM_POS * CODE_W
) (
   input logic               clk,
   input logic               rst_n,
   input logic               ce1_n,
   input logic               ce2_n,
   input logic               wr_n,
   input logic               cur_sel,
   input logic               clr_n,
   input logic               blank_n,
   input logic [ADDR_W-1:0]  scan_pos,
   input logic [FLAT_W-1:0]  char_flat,
   input logic [NUM_POS-1:0] cur_flat
);

   function automatic logic [CODE_W-1:0] slot(input logic [FLAT_W-1:0] f,
                                              input logic [ADDR_W-1:0] a);
      logic [CODE_W-1:0] r;
      r = '0;
      for (int k = 0; k < NUM_POS; k++) begin
         if (a == ADDR_W'(k)) r = f[k*CODE_W +: CODE_W];
      end
      return r;
   endfunction

   logic strobe_in;
   logic clr_in;
   assign strobe_in = !ce1_n && !ce2_n && !wr_n;
   assign clr_in    = !clr_n && blank_n;

   AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!strobe_in && !clr_in) |=> ($stable(char_flat) && $stable(cur_flat))); // R3

   AST_CURSOR_KEEPS_CHAR: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe_in && !cur_sel && !clr_in) |=> $stable(char_flat)); // R4

   AST_CLEAR_ZEROES_SCAN: assert property (@(posedge clk) disable iff (!rst_n)
      clr_in |=> (slot(char_flat, $past(scan_pos)) == '0)); // R6

   AST_CLEAR_KEEPS_CURSOR: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_in && !(strobe_in && !cur_sel)) |=> $stable(cur_flat)); // R7

   AST_BLANK_NO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (!blank_n && !strobe_in) |=> $stable(char_flat)); // R8

   AST_SCAN_HOME: assert property (@(posedge clk) disable iff (!rst_n)
      !blank_n |=> (scan_pos == '0)); // R9

   AST_SCAN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (blank_n && $past(blank_n) && scan_pos != $past(scan_pos))
      |-> (scan_pos == $past(scan_pos) + ADDR_W'(1))); // R9

endmodule

bind char_cursor_store chstore_chk #(
   .NUM_POS (NUM_POS),
   .CODE_W  (CODE_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ce1_n     (ce1_n),
   .ce2_n     (ce2_n),
   .wr_n      (wr_n),
   .cur_sel   (cur_sel),
   .clr_n     (clr_n),
   .blank_n   (blank_n),
   .scan_pos  (scan_pos),
   .char_flat (char_flat),
   .cur_flat  (cur_flat)
);

// File: tb/char_cursor_store_tb.sv
module char_cursor_store_tb;

   localparam int NP   = 4;
   localparam int CW   = 7;
   localparam int STEP = 4;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       ce1_n, ce2_n, wr_n, cur_sel, clr_n, blank_n;
   logic [1:0] wr_addr, rd_addr;
   logic [6:0] wr_data;
   logic [6:0] rd_code;
   logic       rd_code_valid, rd_cursor;
   logic [1:0] scan_pos;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   logic [6:0] m_char [NP];
   logic       m_cur  [NP];
   logic [1:0] m_pos;
   int         m_div;

   always #5 clk = ~clk;

   char_cursor_store #(.NUM_POS(NP), .CODE_W(CW), .STEP_CYC(STEP)) u_dut (
      .clk           (clk),
      .rst_n         (rst_n),
      .ce1_n         (ce1_n),
      .ce2_n         (ce2_n),
      .wr_n          (wr_n),
      .cur_sel       (cur_sel),
      .wr_addr       (wr_addr),
      .wr_data       (wr_data),
      .clr_n         (clr_n),
      .blank_n       (blank_n),
      .rd_addr       (rd_addr),
      .rd_code       (rd_code),
      .rd_code_valid (rd_code_valid),
      .rd_cursor     (rd_cursor),
      .scan_pos      (scan_pos)
   );

   function automatic logic exp_valid(input logic [6:0] c);
      return c[6] != c[5];
   endfunction

   task automatic check(input string tag, input int got, input int exp);
      n_tests++;
      if (got != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
      end
   endtask

   task automatic check_all(input string tag);
      for (int i = 0; i < NP; i++) begin
         rd_addr = 2'(i);
         #1;
         check({tag, " code"},  int'(rd_code),       int'(m_char[i]));
         check({tag, " valid"}, int'(rd_code_valid), int'(exp_valid(m_char[i])));
         check({tag, " cursor"}, int'(rd_cursor),    int'(m_cur[i]));
      end
      check({tag, " scan"}, int'(scan_pos), int'(m_pos));
   endtask

   task automatic idle_inputs();
      ce1_n = 1'b1; ce2_n = 1'b1; wr_n = 1'b1; cur_sel = 1'b1;
      wr_addr = '0; wr_data = '0; clr_n = 1'b1; blank_n = 1'b1;
   endtask

   // one clock: inputs already set at the falling edge
   task automatic cycle();
      logic       we;
      logic       clr_hit;
      logic [1:0] pos_before;
      @(posedge clk);
      #1;
      we         = !ce1_n && !ce2_n && !wr_n;
      pos_before = m_pos;
      clr_hit    = !clr_n && blank_n;
      if (clr_hit) m_char[pos_before] = '0;
      if (we && cur_sel && !(clr_hit && wr_addr == pos_before)) m_char[wr_addr] = wr_data;
      if (we && !cur_sel) m_cur[wr_addr] = wr_data[0];
      if (!blank_n) begin
         m_pos = '0; m_div = 0;
      end else if (m_div == STEP - 1) begin
         m_div = 0; m_pos = m_pos + 2'd1;
      end else begin
         m_div++;
      end
      @(negedge clk);
   endtask

   task automatic write(input logic cs, input logic [1:0] a, input logic [6:0] d);
      ce1_n = 1'b0; ce2_n = 1'b0; wr_n = 1'b0; cur_sel = cs;
      wr_addr = a; wr_data = d;
      cycle();
      ce1_n = 1'b1; ce2_n = 1'b1; wr_n = 1'b1;
   endtask

   initial begin
      #(2_000_000);
      if (!done) begin
         n_fail++;
         n_tests++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      idle_inputs();
      rd_addr = '0;
      rst_n   = 1'b0;
      for (int i = 0; i < NP; i++) begin
         m_char[i] = '0; m_cur[i] = 1'b0;
      end
      m_pos = '0; m_div = 0;
      repeat (3) @(negedge clk);
      check_all("R1");
      rst_n = 1'b1;
      @(negedge clk);
      // the cycle above ran with idle inputs; advance the model by one step
      m_div = 1;
      check_all("R1");

      // R2 and R5: character writes, valid and blank codes
      write(1'b1, 2'd0, 7'h41);
      check_all("R2");
      write(1'b1, 2'd3, 7'h7F);
      check_all("R5");
      write(1'b1, 2'd1, 7'h1A);
      check_all("R5");
      write(1'b1, 2'd2, 7'h35);
      check_all("R2");

      // R3: each enable alone blocks the write
      ce1_n = 1'b1; ce2_n = 1'b0; wr_n = 1'b0; cur_sel = 1'b1; wr_addr = 2'd0; wr_data = 7'h55;
      cycle(); check_all("R3");
      ce1_n = 1'b0; ce2_n = 1'b1; cycle(); check_all("R3");
      ce2_n = 1'b0; wr_n = 1'b1; cycle(); check_all("R3");
      cur_sel = 1'b0; wr_data = 7'h01; cycle(); check_all("R3");
      idle_inputs();

      // R4: cursor set and remove, character untouched
      write(1'b0, 2'd2, 7'h01);
      check_all("R4");
      write(1'b0, 2'd0, 7'h7F);
      check_all("R4");
      write(1'b0, 2'd2, 7'h7E);
      check_all("R4");
      write(1'b0, 2'd1, 7'h01);
      check_all("R4");

      // R6 and R7: scan-ordered clear with a cursor write during it
      clr_n = 1'b0;
      for (int c = 0; c < NP * STEP; c++) begin
         if (c == 5) begin
            ce1_n = 1'b0; ce2_n = 1'b0; wr_n = 1'b0; cur_sel = 1'b0;
            wr_addr = 2'd3; wr_data = 7'h01;
         end else begin
            ce1_n = 1'b1; ce2_n = 1'b1; wr_n = 1'b1;
         end
         cycle();
         check_all("R6");
      end
      for (int i = 0; i < NP; i++) check("R6 all zero", int'(m_char[i]), 0);
      check_all("R7");
      idle_inputs();

      // R8 and R9: blanking inhibits clear, writes still land, scan held at 0
      blank_n = 1'b0; clr_n = 1'b0;
      write(1'b1, 2'd1, 7'h52);
      check_all("R8");
      write(1'b0, 2'd0, 7'h01);
      check_all("R8");
      for (int c = 0; c < 6; c++) begin
         cycle();
         check_all("R9");
      end
      idle_inputs();
      for (int c = 0; c < 9; c++) begin
         cycle();
         check_all("R9");
      end

      // R10: clear and write to the scanned position in the same cycle
      write(1'b1, 2'd0, 7'h44);
      write(1'b1, 2'd2, 7'h45);
      clr_n = 1'b0;
      ce1_n = 1'b0; ce2_n = 1'b0; wr_n = 1'b0; cur_sel = 1'b1;
      wr_addr = m_pos; wr_data = 7'h4B;
      cycle();
      check_all("R10");
      idle_inputs();

      // random mix
      for (int c = 0; c < 400; c++) begin
         ce1_n   = ($urandom % 4) == 0;
         ce2_n   = ($urandom % 4) == 0;
         wr_n    = ($urandom % 4) == 0;
         cur_sel = ($urandom % 3) != 0;
         wr_addr = 2'($urandom);
         wr_data = 7'($urandom);
         clr_n   = ($urandom % 8) != 0;
         blank_n = ($urandom % 8) != 0;
         cycle();
         check_all("R2,R4,R6 random");
      end

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule